// File: doc/BRIEF.md
# Byte-Access Word Error-Correction Unit

This block sits between a byte-addressed requester and a storage array whose entries are 38-bit code words. Each word holds 32 data bits and 6 check bits, arranged as a single-error-correcting Hamming code. On a read, the unit fetches the word and computes the syndrome. It flips the single faulty bit if the syndrome names one, then returns the byte selected by the low address bits.

Writes are handled according to how much of the word they cover. A write that enables all four byte lanes is encoded and stored directly, without reading the array first. A write that covers only some lanes uses a read-modify-write sequence:

1. Fetch the old word.
2. Correct it.
3. Overlay the enabled lanes.
4. Re-encode the result.
5. Store the whole word.

Because the merge starts from the corrected word, every partial write also scrubs a latent single-bit fault in that word.

The unit accepts one request at a time and holds `req_ready` low until the operation finishes. Two one-cycle pulses report what the decoder saw: `ecc_corrected` and `ecc_uncorr`. These pulse for reads and for the read phase of partial writes alike.

Top module: `ecc_rmw_unit`

## Requirements
- R1: Code word bit p-1 holds Hamming position p, for p from 1 to 38. Check bits sit at positions 1, 2, 4, 8, 16 and 32. Data bit i goes to the i-th non-power-of-two position in ascending order, so data bit 0 is at position 3. The check bit at position 2^k is even parity over all other positions whose index has bit k set.
- R2: A write with `req_be` = 4'b1111 drives `mem_wr_en` with the encoded word in the cycle after acceptance. It issues no array read.
- R3: A write with any other `req_be` does the following. It reads the array in the cycle after acceptance. It drives `mem_wr_en` two cycles later. Lanes with a 1 in `req_be` (bit n covers data bits 8n+7..8n) take the new data. The other lanes keep the old corrected content.
- R4: A read returns byte lane `req_addr[1:0]` of word `req_addr[ADDR_W-1:2]`. `rsp_valid` is high for exactly one cycle, three cycles after acceptance.
- R5: A single flipped bit at any of the 38 positions is corrected on read, and `ecc_corrected` pulses together with `rsp_valid`.
- R6: A syndrome from 39 to 63 pulses `ecc_uncorr` without `ecc_corrected`, and the data is returned as stored, without any flip.
- R7: A partial write to a word that holds a single-bit fault stores a clean encoding of the corrected-and-merged data, and `ecc_corrected` pulses in the array-write cycle.
- R8: `req_ready` is low from the cycle after acceptance until the operation completes. A request held on the inputs during that time is not taken and causes no array access.
- R9: During and right after reset, `req_ready` is high and `mem_rd_en`, `mem_wr_en`, `rsp_valid`, `ecc_corrected` and `ecc_uncorr` are low.
- R10: Every read and every partial write issues `mem_rd_en` with `mem_addr` equal to the word index in the cycle after acceptance. The array returns the word in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle, request will be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address; upper bits give the word index, low two bits the lane for reads |
| req_be | input | 4 | Byte-lane write enables |
| req_wdata | input | 32 | Write data, lane n in bits 8n+7..8n |
| rsp_valid | output | 1 | Read byte valid (one cycle) |
| rsp_data | output | 8 | Read byte |
| ecc_corrected | output | 1 | Single-bit fault corrected (pulse) |
| ecc_uncorr | output | 1 | Syndrome out of range (pulse) |
| mem_rd_en | output | 1 | Array read strobe |
| mem_wr_en | output | 1 | Array write strobe |
| mem_addr | output | ADDR_W-2 | Array word index |
| mem_wdata | output | 38 | Code word to store |
| mem_rdata | input | 38 | Code word read, valid the cycle after `mem_rd_en` |

## Verification
The bench builds the unit with ADDR_W = 8, which gives a 64-word array. A behavioural array model of that size stays tiny while still reaching the top word index. The same small array lets the bench do the following:
- corrupt stored words directly between operations;
- sweep a single fault over all 38 positions;
- build a two-bit fault whose syndrome lands above 38.

The reference model re-derives the code layout from the positional rule and checks every cycle of each operation against the expected strobes, addresses, words and flags. This includes the cycles in which a second request is held against a busy unit.

// File: rtl/ecc_rmw_pkg.sv
package ecc_rmw_pkg;
  localparam int DATA_W  = 32;
  localparam int CHK_W   = 6;
  localparam int CODE_W  = DATA_W + CHK_W;
  localparam int LANES   = DATA_W / 8;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WAIT  = 2'd2,
    ST_WRITE = 2'd3
  } rmw_state_t;

  function automatic bit is_check_pos(int p);
    return (p & (p - 1)) == 0;
  endfunction

  // scatter data bits over the non-check positions, check bits left zero
  function automatic logic [CODE_W-1:0] scatter_data(logic [DATA_W-1:0] d);
    logic [CODE_W-1:0] cw;
    int idx;
    cw  = '0;
    idx = 0;
    for (int p = 1; p <= CODE_W; p++) begin
      if (!is_check_pos(p)) begin
        cw[p-1] = d[idx];
        idx++;
      end
    end
    return cw;
  endfunction

  function automatic logic [DATA_W-1:0] gather_data(logic [CODE_W-1:0] cw);
    logic [DATA_W-1:0] d;
    int idx;
    d   = '0;
    idx = 0;
    for (int p = 1; p <= CODE_W; p++) begin
      if (!is_check_pos(p)) begin
        d[idx] = cw[p-1];
        idx++;
      end
    end
    return d;
  endfunction

  function automatic logic [CHK_W-1:0] position_xor(logic [CODE_W-1:0] cw);
    logic [CHK_W-1:0] s;
    s = '0;
    for (int p = 1; p <= CODE_W; p++) begin
      if (cw[p-1]) s = s ^ p[CHK_W-1:0];
    end
    return s;
  endfunction
endpackage

// File: rtl/ecc_word_enc.sv
module ecc_word_enc
  import ecc_rmw_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  output logic [CODE_W-1:0] code_o
);
  logic [CODE_W-1:0] bare;
  logic [CHK_W-1:0]  par;

  always_comb begin
    bare   = scatter_data(data_i);
    par    = position_xor(bare);
    code_o = bare;
    for (int k = 0; k < CHK_W; k++) begin
      code_o[(1 << k) - 1] = par[k];
    end
  end
endmodule

// File: rtl/ecc_word_dec.sv
module ecc_word_dec
  import ecc_rmw_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  output logic [DATA_W-1:0] data_o,
  output logic              fixed_o,
  output logic              bad_o
);
  localparam logic [CHK_W-1:0] LAST_POS = CHK_W'(CODE_W);

  logic [CHK_W-1:0]  syn;
  logic [CODE_W-1:0] flip;

  always_comb begin
    syn     = position_xor(code_i);
    fixed_o = (syn != '0) && (syn <= LAST_POS);
    bad_o   = (syn > LAST_POS);
    flip    = '0;
    if (fixed_o) flip[syn - 1'b1] = 1'b1;
    data_o  = gather_data(code_i ^ flip);
  end
endmodule

// File: rtl/ecc_lane_merge.sv
module ecc_lane_merge
  import ecc_rmw_pkg::*;
(
  input  logic [DATA_W-1:0] old_i,
  input  logic [DATA_W-1:0] new_i,
  input  logic [LANES-1:0]  be_i,
  output logic [DATA_W-1:0] out_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign out_o[g*8 +: 8] = be_i[g] ? new_i[g*8 +: 8] : old_i[g*8 +: 8];
  end
endmodule

// File: rtl/ecc_rmw_unit.sv
module ecc_rmw_unit
  import ecc_rmw_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [3:0]           req_be,
  input  logic [31:0]          req_wdata,
  output logic                 rsp_valid,
  output logic [7:0]           rsp_data,
  output logic                 ecc_corrected,
  output logic                 ecc_uncorr,
  output logic                 mem_rd_en,
  output logic                 mem_wr_en,
  output logic [ADDR_W-3:0]    mem_addr,
  output logic [37:0]          mem_wdata,
  input  logic [37:0]          mem_rdata
);
  localparam int WIDX_W = ADDR_W - 2;

  rmw_state_t          state_q, state_d;
  logic [WIDX_W-1:0]   widx_q;
  logic [1:0]          lane_q;
  logic [LANES-1:0]    be_q;
  logic [DATA_W-1:0]   new_q;
  logic [DATA_W-1:0]   word_q, word_d;
  logic                is_wr_q;
  logic                rsp_valid_q, corr_q, unc_q;
  logic [7:0]          rsp_data_q;

  logic                accept, full_wr, word_en, in_wait;
  logic [DATA_W-1:0]   dec_data, merged;
  logic                dec_fix, dec_bad;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign full_wr   = req_write && (&req_be);
  assign in_wait   = (state_q == ST_WAIT);

  ecc_word_dec u_dec (
    .code_i  (mem_rdata),
    .data_o  (dec_data),
    .fixed_o (dec_fix),
    .bad_o   (dec_bad)
  );

  ecc_lane_merge u_merge (
    .old_i (dec_data),
    .new_i (new_q),
    .be_i  (be_q),
    .out_o (merged)
  );

  ecc_word_enc u_enc (
    .data_i (word_q),
    .code_o (mem_wdata)
  );

  // next state
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (accept) state_d = full_wr ? ST_WRITE : ST_READ;
      ST_READ:  state_d = ST_WAIT;
      ST_WAIT:  state_d = is_wr_q ? ST_WRITE : ST_IDLE;
      ST_WRITE: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    word_en = 1'b0;
    word_d  = word_q;
    if (accept) begin
      word_en = 1'b1;
      word_d  = req_wdata;
    end else if (in_wait && is_wr_q) begin
      word_en = 1'b1;
      word_d  = merged;
    end
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      rsp_valid_q <= 1'b0;
      corr_q      <= 1'b0;
      unc_q       <= 1'b0;
    end else begin
      state_q     <= state_d;
      rsp_valid_q <= in_wait && !is_wr_q;
      corr_q      <= in_wait && dec_fix;
      unc_q       <= in_wait && dec_bad;
    end
  end

  // datapath registers, enabled loads only
  always_ff @(posedge clk) begin
    if (accept) begin
      widx_q  <= req_addr[ADDR_W-1:2];
      lane_q  <= req_addr[1:0];
      be_q    <= req_be;
      new_q   <= req_wdata;
      is_wr_q <= req_write;
    end
    if (word_en) word_q <= word_d;
    if (in_wait && !is_wr_q) rsp_data_q <= dec_data[{lane_q, 3'b000} +: 8];
  end

  assign mem_rd_en     = (state_q == ST_READ);
  assign mem_wr_en     = (state_q == ST_WRITE);
  assign mem_addr      = widx_q;
  assign rsp_valid     = rsp_valid_q;
  assign rsp_data      = rsp_data_q;
  assign ecc_corrected = corr_q;
  assign ecc_uncorr    = unc_q;

  // full-lane writes skip the array read
  p_full_write_direct_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_write && (&req_be)) |=> (mem_wr_en && !mem_rd_en));
  // reads and partial writes fetch first
  p_read_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !(req_write && (&req_be))) |=> mem_rd_en);
  p_rd_wr_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_en && mem_wr_en));
  p_read_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> (!req_ready && !mem_rd_en && !mem_wr_en));
  p_write_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |=> req_ready);
  p_rsp_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  p_flag_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ecc_uncorr |-> !ecc_corrected);
endmodule

// File: tb/tb_ecc_rmw_unit.sv
module tb_ecc_rmw_unit;
  localparam int AW = 8;
  localparam int NWORDS = 1 << (AW - 2);

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_ready, req_write;
  logic [AW-1:0] req_addr;
  logic [3:0] req_be;
  logic [31:0] req_wdata;
  logic rsp_valid, ecc_corrected, ecc_uncorr, mem_rd_en, mem_wr_en;
  logic [7:0] rsp_data;
  logic [AW-3:0] mem_addr;
  logic [37:0] mem_wdata, mem_rdata;

  logic [37:0] bmem [0:NWORDS-1];
  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ecc_rmw_unit #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_be(req_be),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .ecc_corrected(ecc_corrected), .ecc_uncorr(ecc_uncorr),
    .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // behavioural array, one cycle read latency
  always @(posedge clk) begin
    if (mem_wr_en) bmem[mem_addr] <= mem_wdata;
    if (mem_rd_en) mem_rdata <= bmem[mem_addr];
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // reference code built from the positional rule (R1)
  function automatic int data_pos(int i);
    int n = -1;
    for (int p = 1; p <= 38; p++) begin
      if (p != 1 && p != 2 && p != 4 && p != 8 && p != 16 && p != 32) n++;
      if (n == i) return p;
    end
    return 0;
  endfunction

  function automatic logic [37:0] ref_enc(logic [31:0] d);
    logic [37:0] cw = '0;
    for (int i = 0; i < 32; i++) cw[data_pos(i)-1] = d[i];
    for (int k = 0; k < 6; k++) begin
      logic par = 1'b0;
      for (int p = 1; p <= 38; p++)
        if (((p >> k) & 1) == 1 && p != (1 << k)) par ^= cw[p-1];
      cw[(1 << k) - 1] = par;
    end
    return cw;
  endfunction

  function automatic logic [31:0] ref_raw(logic [37:0] cw);
    logic [31:0] d;
    for (int i = 0; i < 32; i++) d[i] = cw[data_pos(i)-1];
    return d;
  endfunction

  function automatic logic [31:0] ref_merge(logic [31:0] o, logic [31:0] n, logic [3:0] be);
    logic [31:0] r = o;
    for (int g = 0; g < 4; g++) if (be[g]) r[g*8 +: 8] = n[g*8 +: 8];
    return r;
  endfunction

  // one operation with per-cycle expectations
  task automatic op(input bit wr, input int addr, input logic [3:0] be, input logic [31:0] d,
                    input logic [37:0] exp_cw, input logic [7:0] exp_b,
                    input bit ec, input bit eu, input bit hold, input string tag);
    bit full = wr && (be == 4'hF);
    int nk = full ? 2 : (wr ? 4 : 3);
    logic [AW-3:0] widx = (AW-2)'(addr >> 2);
    chk(req_ready == 1'b1, "R8 ready before request", 64'(req_ready), 64'd1);
    req_valid = 1'b1; req_write = wr; req_addr = AW'(addr); req_be = be; req_wdata = d;
    @(posedge clk);
    for (int k = 1; k <= nk; k++) begin
      @(negedge clk);
      if (k == 1) begin
        if (hold) begin
          req_write = 1'b1; req_be = 4'hF; req_addr = AW'(12*4); req_wdata = 32'hDEADBEEF;
        end else req_valid = 1'b0;
      end
      if (k == nk) req_valid = 1'b0;
      if (k < nk) chk(req_ready == 1'b0, "R8 busy", 64'(req_ready), 64'd0);
      else        chk(req_ready == 1'b1, "R8 done", 64'(req_ready), 64'd1);
      if (full) begin
        if (k == 1) begin
          chk(mem_wr_en && !mem_rd_en, "R2 direct write", {62'd0, mem_wr_en, mem_rd_en}, 64'd2);
          chk(mem_addr == widx, "R2 addr", 64'(mem_addr), 64'(widx));
          chk(mem_wdata == exp_cw, {tag, " word"}, 64'(mem_wdata), 64'(exp_cw));
        end
      end else begin
        if (k == 1) begin
          chk(mem_rd_en && !mem_wr_en, "R10 read strobe", {62'd0, mem_wr_en, mem_rd_en}, 64'd1);
          chk(mem_addr == widx, "R10 addr", 64'(mem_addr), 64'(widx));
        end
        if (k == 2) chk(!mem_rd_en && !mem_wr_en, "R10 wait", {62'd0, mem_wr_en, mem_rd_en}, 64'd0);
        if (k == 3) begin
          chk(ecc_corrected == ec, {tag, " corrected flag"}, 64'(ecc_corrected), 64'(ec));
          chk(ecc_uncorr == eu, {tag, " uncorr flag"}, 64'(ecc_uncorr), 64'(eu));
          if (wr) begin
            chk(mem_wr_en && !rsp_valid, "R3 write phase", {62'd0, mem_wr_en, rsp_valid}, 64'd2);
            chk(mem_wdata == exp_cw, {tag, " merged word"}, 64'(mem_wdata), 64'(exp_cw));
          end else begin
            chk(rsp_valid == 1'b1, "R4 rsp_valid", 64'(rsp_valid), 64'd1);
            chk(rsp_data == exp_b, {tag, " byte"}, 64'(rsp_data), 64'(exp_b));
          end
        end
        if (k == 4 || (k == 3 && !wr)) chk(!mem_wr_en && !mem_rd_en || k == 3, "R3 ends", {62'd0, mem_wr_en, mem_rd_en}, 64'd0);
      end
    end
    @(negedge clk);
    chk(!mem_rd_en && !mem_wr_en && !rsp_valid, "R8 idle after op",
        {61'd0, rsp_valid, mem_wr_en, mem_rd_en}, 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] w5, pat, nd;
    logic [37:0] cw;
    req_valid = 0; req_write = 0; req_addr = '0; req_be = '0; req_wdata = '0;
    for (int i = 0; i < NWORDS; i++) bmem[i] = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk(req_ready && !mem_rd_en && !mem_wr_en && !rsp_valid && !ecc_corrected && !ecc_uncorr,
        "R9 reset state", {58'd0, req_ready, mem_rd_en, mem_wr_en, rsp_valid, ecc_corrected, ecc_uncorr},
        64'h20);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready && !mem_rd_en && !mem_wr_en, "R9 after release",
        {61'd0, req_ready, mem_rd_en, mem_wr_en}, 64'h4);

    // full writes (R1, R2)
    w5 = 32'hA1B2C3D4;
    op(1, 5*4, 4'hF, w5, ref_enc(w5), 8'h0, 0, 0, 0, "R1 R2 full");
    op(1, 63*4, 4'hF, 32'h0F0F5AA5, ref_enc(32'h0F0F5AA5), 8'h0, 0, 0, 0, "R2 top word");
    op(1, 12*4, 4'hF, 32'h12345678, ref_enc(32'h12345678), 8'h0, 0, 0, 0, "R2 word12");

    // reads of every lane (R4)
    for (int l = 0; l < 4; l++)
      op(0, 5*4 + l, 4'h0, 32'h0, '0, w5[l*8 +: 8], 0, 0, 0, "R4 lane read");
    op(0, 63*4 + 3, 4'h0, 32'h0, '0, 8'h0F, 0, 0, 0, "R4 top word");

    // partial write (R3)
    nd = 32'h99887766;
    w5 = ref_merge(w5, nd, 4'b0101);
    op(1, 5*4, 4'b0101, nd, ref_enc(w5), 8'h0, 0, 0, 0, "R3 partial");
    for (int l = 0; l < 4; l++)
      op(0, 5*4 + l, 4'h0, 32'h0, '0, w5[l*8 +: 8], 0, 0, 0, "R3 readback");

    // single-bit faults at every position (R5)
    for (int p = 1; p <= 38; p++) begin
      pat = 32'h3C5A_0000 ^ (32'h01010101 * p);
      op(1, 7*4, 4'hF, pat, ref_enc(pat), 8'h0, 0, 0, 0, "R2 fault setup");
      bmem[7][p-1] = ~bmem[7][p-1];
      op(0, 7*4 + (p % 4), 4'h0, 32'h0, '0, pat[(p%4)*8 +: 8], 1, 0, 0, "R5 corrected read");
    end

    // out-of-range syndrome 33^6 = 39 (R6)
    pat = 32'hCAFEF00D;
    op(1, 8*4, 4'hF, pat, ref_enc(pat), 8'h0, 0, 0, 0, "R2 setup");
    cw = ref_enc(pat);
    cw[32] = ~cw[32]; cw[5] = ~cw[5];
    bmem[8] = cw;
    for (int l = 0; l < 4; l++)
      op(0, 8*4 + l, 4'h0, 32'h0, '0, ref_raw(cw)[l*8 +: 8], 0, 1, 0, "R6 uncorrectable");

    // scrub on partial write (R7)
    pat = 32'h55AA33CC;
    op(1, 9*4, 4'hF, pat, ref_enc(pat), 8'h0, 0, 0, 0, "R2 setup");
    bmem[9][9] = ~bmem[9][9];
    nd = 32'h000000E7;
    op(1, 9*4, 4'b0001, nd, ref_enc(ref_merge(pat, nd, 4'b0001)), 8'h0, 1, 0, 0, "R7 scrub");
    @(negedge clk);
    chk(bmem[9] == ref_enc(ref_merge(pat, nd, 4'b0001)), "R7 stored clean",
        64'(bmem[9]), 64'(ref_enc(ref_merge(pat, nd, 4'b0001))));

    // request held while busy is not taken (R8)
    op(0, 5*4 + 1, 4'h0, 32'h0, '0, w5[15:8], 0, 0, 1, "R8 held read");
    op(1, 9*4 + 2, 4'b1100, 32'h4321_0000, ref_enc(ref_merge(ref_merge(pat, nd, 4'b0001), 32'h43210000, 4'b1100)),
       8'h0, 0, 0, 1, "R8 held rmw");
    chk(bmem[12] == ref_enc(32'h12345678), "R8 word12 untouched",
        64'(bmem[12]), 64'(ref_enc(32'h12345678)));

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule